// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block turns a 32-bit virtual address into a physical address by walking an in-memory translation table. A request is one start pulse carrying the address, the access kind (read, write or instruction fetch) and whether the access is unprivileged. The walker reads a first-level descriptor and, for table entries, a second-level descriptor through a single read port with a valid/ready handshake. Each descriptor read completes in the cycle where both signals are high, and the word is on the data input in that cycle.

The first-level entry either maps a 1 MB section directly or points to a coarse or fine second-level table. The second-level entry maps a 64 KB, 4 KB or 1 KB page. Every translation also passes a domain check and an access-permission check. Under a domain whose access value is 3, the permission check is skipped. The walker ends each translation with a one-cycle done pulse. With that pulse it reports either the physical address or a fault status byte. The upper nibble of that byte is the domain index and the lower nibble is a fault code.

Before any of this, addresses below 0x02000000 are shifted by a process offset. When the enable input is low, the shifted address is returned unchanged and no descriptor is read.

Top module: `xlat_walker`

## Requirements
- R1: A virtual address below 0x02000000 has `cfg_pid` added to it before translation; addresses at or above that limit are used as given.
- R2: With `cfg_en` low, `done` rises the cycle after `start`, `pa` equals the remapped address, `fault` is 0, and no descriptor read is issued.
- R3: The first descriptor read uses address {cfg_base[31:14], va[31:20], 2'b00}. A first-level descriptor whose bits 1:0 are 0 gives fault code 5.
- R4: The domain index is first-level bits 8:5. It selects the 2-bit value at cfg_dacr[2*index+1 : 2*index]. Values 0 and 2 fault with code 9 for a section (type 2) and 11 for a table (type 1 or 3). Value 3 grants any access with no permission check.
- R5: A section (type 2) yields pa = {desc[31:20], va[19:0]}, and its permission field is desc[11:10]. A permission failure reports code 13.
- R6: A table entry causes a second read at {l1[31:10], va[19:12], 2'b00}. A second-level type 0 (bits 1:0) gives fault code 7.
- R7: Second-level type 1 is a 64 KB page, pa = {d[31:16], va[15:0]}, with permission field d[5+2k:4+2k] where k = va[15:14]. Type 2 is a 4 KB page, pa = {d[31:12], va[11:0]}, with k = va[11:10].
- R8: Second-level type 3 is a 1 KB page, pa = {d[31:10], va[9:0]}, with permission field d[5:4]. It faults with code 7 when the first-level type was 1. A page permission failure reports code 15.
- R9: Permission 0 refuses writes. For reads and fetches it obeys `cfg_pmode`: 01 allows privileged accesses only, 10 allows everyone, and 00 or 11 refuses all.
- R10: Permission 1 refuses all unprivileged accesses. Permission 2 refuses unprivileged writes. Permission 3 allows everything. Privileged accesses are always allowed under 1 and 2.
- R11: On a fault, `fstat` = {domain index, code}.
- R12: `rd_valid` and `rd_addr` hold steady until `rd_ready`. `done` is high for exactly one cycle per translation.
- R13: Access kind encoding: 0 read, 1 write, 2 fetch. A fetch is judged as a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a translation (taken when idle) |
| va | input | 32 | Virtual address |
| acc | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| user | input | 1 | 1 for an unprivileged access |
| cfg_en | input | 1 | Translation enable |
| cfg_base | input | 32 | Translation table base (bits 31:14 used) |
| cfg_dacr | input | 32 | Sixteen 2-bit domain access values |
| cfg_pid | input | 32 | Process offset for low addresses |
| cfg_pmode | input | 2 | Mode bits for permission 0 reads |
| rd_valid | output | 1 | Descriptor read request |
| rd_addr | output | 32 | Descriptor address |
| rd_ready | input | 1 | Read accepted; data valid this cycle |
| rd_data | input | 32 | Descriptor word |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Translation faulted |
| fstat | output | 8 | Fault status {domain, code} |
| pa | output | 32 | Physical address (valid when not faulted) |

## Verification
The domain decision and the permission decision are made in the same descriptor-evaluation cycle, and the domain value 3 must override a permission field that would refuse the access. The bench provokes this by programming descriptors whose permission bits deny the access under every mode setting, then sweeping all four domain values. A fault code of 9, 11, 13 or 15, or a clean grant, is then expected purely from the domain value. The remap and the disabled bypass also meet at acceptance. Addresses on either side of the remap limit are sent with translation off, and the returned address must carry the offset exactly where R1 says.

// File: rtl/xw_pkg.sv
package xw_pkg;
    localparam int unsigned VA_W = 32;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LVL1 = 2'd1,
        ST_LVL2 = 2'd2
    } wstate_e;

    localparam logic [3:0] FC_SECT_XLAT = 4'd5;
    localparam logic [3:0] FC_PAGE_XLAT = 4'd7;
    localparam logic [3:0] FC_SECT_DOM  = 4'd9;
    localparam logic [3:0] FC_PAGE_DOM  = 4'd11;
    localparam logic [3:0] FC_SECT_PERM = 4'd13;
    localparam logic [3:0] FC_PAGE_PERM = 4'd15;

    typedef struct packed {
        logic        fault;
        logic [7:0]  fstat;
        logic [31:0] pa;
    } result_t;

    function automatic logic [7:0] mk_fstat(input logic [3:0] dom, input logic [3:0] code);
        return {dom, code};
    endfunction
endpackage

// File: rtl/xw_remap.sv
module xw_remap #(
    parameter int unsigned W = 32,
    parameter logic [31:0] LIMIT = 32'h0200_0000
) (
    input  logic [W-1:0] va,
    input  logic [W-1:0] offset,
    output logic [W-1:0] mva
);
    always_comb begin
        if (va < LIMIT[W-1:0]) mva = va + offset;
        else                   mva = va;
    end
endmodule

// File: rtl/xw_access.sv
module xw_access (
    input  logic [1:0] dom_val,
    input  logic [1:0] ap,
    input  logic [1:0] pmode,
    input  logic       user,
    input  logic       is_wr,
    output logic       dom_fault,
    output logic       grant
);
    logic ap_ok;

    always_comb begin
        unique case (ap)
            2'd0: begin
                if (is_wr)                ap_ok = 1'b0;
                else if (pmode == 2'b01)  ap_ok = !user;
                else if (pmode == 2'b10)  ap_ok = 1'b1;
                else                      ap_ok = 1'b0;
            end
            2'd1:    ap_ok = !user;
            2'd2:    ap_ok = !(user && is_wr);
            default: ap_ok = 1'b1;
        endcase
    end

    assign dom_fault = (dom_val == 2'd0) || (dom_val == 2'd2);
    assign grant     = (dom_val == 2'd3) || ((dom_val == 2'd1) && ap_ok);
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
    import xw_pkg::*;
#(
    parameter logic [31:0] REMAP_LIMIT = 32'h0200_0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [31:0] va,
    input  logic [1:0]  acc,
    input  logic        user,
    input  logic        cfg_en,
    input  logic [31:0] cfg_base,
    input  logic [31:0] cfg_dacr,
    input  logic [31:0] cfg_pid,
    input  logic [1:0]  cfg_pmode,
    output logic        rd_valid,
    output logic [31:0] rd_addr,
    input  logic        rd_ready,
    input  logic [31:0] rd_data,
    output logic        done,
    output logic        fault,
    output logic [7:0]  fstat,
    output logic [31:0] pa
);
    wstate_e     st;
    logic [31:0] mva_q, l1_q;
    logic        user_q, wr_q;
    logic [31:0] mva_in;
    result_t     res_q;

    xw_remap #(.W(VA_W), .LIMIT(REMAP_LIMIT)) u_remap (
        .va(va), .offset(cfg_pid), .mva(mva_in)
    );

    // descriptor evaluation
    logic [31:0] desc, l1_view;
    logic [3:0]  dom_idx;
    logic [1:0]  dom_val, ap_sel, k_sel;
    logic [31:0] pa_cand;
    logic        dom_fault, grant;

    assign desc    = rd_data;
    assign l1_view = (st == ST_LVL1) ? rd_data : l1_q;
    assign dom_idx = l1_view[8:5];
    assign dom_val = cfg_dacr[{dom_idx, 1'b0} +: 2];

    always_comb begin
        k_sel   = 2'd0;
        ap_sel  = desc[5:4];
        pa_cand = {desc[31:10], mva_q[9:0]};
        if (st == ST_LVL1) begin
            ap_sel  = desc[11:10];
            pa_cand = {desc[31:20], mva_q[19:0]};
        end else begin
            unique case (desc[1:0])
                2'd1: begin
                    k_sel   = mva_q[15:14];
                    ap_sel  = desc[{k_sel, 1'b0} + 4 +: 2];
                    pa_cand = {desc[31:16], mva_q[15:0]};
                end
                2'd2: begin
                    k_sel   = mva_q[11:10];
                    ap_sel  = desc[{k_sel, 1'b0} + 4 +: 2];
                    pa_cand = {desc[31:12], mva_q[11:0]};
                end
                default: begin
                    ap_sel  = desc[5:4];
                    pa_cand = {desc[31:10], mva_q[9:0]};
                end
            endcase
        end
    end

    xw_access u_access (
        .dom_val(dom_val), .ap(ap_sel), .pmode(cfg_pmode), .user(user_q),
        .is_wr(wr_q), .dom_fault(dom_fault), .grant(grant)
    );

    function automatic result_t flt(input logic [3:0] d, input logic [3:0] c);
        result_t r;
        r.fault = 1'b1;
        r.fstat = mk_fstat(d, c);
        r.pa    = '0;
        return r;
    endfunction

    function automatic result_t ok(input logic [31:0] p);
        result_t r;
        r.fault = 1'b0;
        r.fstat = '0;
        r.pa    = p;
        return r;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            mva_q  <= '0;
            l1_q   <= '0;
            user_q <= 1'b0;
            wr_q   <= 1'b0;
            res_q  <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (st)
                ST_IDLE: if (start) begin
                    mva_q  <= mva_in;
                    user_q <= user;
                    wr_q   <= (acc == ACC_WRITE);
                    if (!cfg_en) begin
                        res_q <= ok(mva_in);
                        done  <= 1'b1;
                    end else begin
                        st <= ST_LVL1;
                    end
                end
                ST_LVL1: if (rd_ready) begin
                    l1_q <= desc;
                    if (desc[1:0] == 2'd0) begin
                        res_q <= flt(dom_idx, FC_SECT_XLAT);
                        done <= 1'b1; st <= ST_IDLE;
                    end else if (dom_fault) begin
                        res_q <= flt(dom_idx, (desc[1:0] == 2'd2) ? FC_SECT_DOM : FC_PAGE_DOM);
                        done <= 1'b1; st <= ST_IDLE;
                    end else if (desc[1:0] == 2'd2) begin
                        res_q <= grant ? ok(pa_cand) : flt(dom_idx, FC_SECT_PERM);
                        done <= 1'b1; st <= ST_IDLE;
                    end else begin
                        st <= ST_LVL2;
                    end
                end
                ST_LVL2: if (rd_ready) begin
                    if (desc[1:0] == 2'd0 || (desc[1:0] == 2'd3 && l1_q[1:0] == 2'd1))
                        res_q <= flt(dom_idx, FC_PAGE_XLAT);
                    else
                        res_q <= grant ? ok(pa_cand) : flt(dom_idx, FC_PAGE_PERM);
                    done <= 1'b1; st <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign rd_valid = (st == ST_LVL1) || (st == ST_LVL2);
    assign rd_addr  = (st == ST_LVL1) ? {cfg_base[31:14], mva_q[31:20], 2'b00}
                                      : {l1_q[31:10], mva_q[19:12], 2'b00};
    assign fault = res_q.fault;
    assign fstat = res_q.fstat;
    assign pa    = res_q.pa;

    // R12
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr));
    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R11
    fault_code_chk: assert property (@(posedge clk) disable iff (rst)
        done && fault |-> fstat[0] && (fstat[3:0] >= 4'd5));
    // R2
    bypass_noread_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !rd_valid);
    // R12
    idle_done_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rd_valid) |-> done);
endmodule

// File: tb/xlat_walker_test.sv
module xlat_walker_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] va = '0;
    logic [1:0]  acc = '0;
    logic        user = 1'b0;
    logic        cfg_en = 1'b0;
    logic [31:0] cfg_base = 32'h0004_C000;
    logic [31:0] cfg_dacr = '0;
    logic [31:0] cfg_pid = '0;
    logic [1:0]  cfg_pmode = '0;
    logic        rd_valid, rd_ready = 1'b0;
    logic [31:0] rd_addr, rd_data = '0;
    logic        done, fault;
    logic [7:0]  fstat;
    logic [31:0] pa;

    int checks = 0;
    int errors = 0;
    logic [31:0] l1d, l2d;
    int nreads;

    xlat_walker uut (.*);

    always #10 clk = ~clk;

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    // reference from the requirements
    function automatic logic [40:0] model(input logic [31:0] v, input logic [1:0] a, input logic u);
        logic [31:0] m, p;
        logic [3:0] d;
        logic [1:0] dv, ap, k;
        logic wr, okp;
        m  = (v < 32'h0200_0000) ? v + cfg_pid : v;
        if (!cfg_en) return {1'b0, 8'h00, m};
        d  = l1d[8:5];
        dv = cfg_dacr[d*2 +: 2];
        wr = (a == 2'd1);
        if (l1d[1:0] == 0) return {1'b1, d, 4'd5, 32'h0};
        if (dv == 0 || dv == 2) return {1'b1, d, (l1d[1:0] == 2) ? 4'd9 : 4'd11, 32'h0};
        if (l1d[1:0] == 2) begin
            p = {l1d[31:20], m[19:0]}; ap = l1d[11:10];
        end else begin
            if (l2d[1:0] == 0 || (l2d[1:0] == 3 && l1d[1:0] == 1)) return {1'b1, d, 4'd7, 32'h0};
            if (l2d[1:0] == 1) begin k = m[15:14]; p = {l2d[31:16], m[15:0]}; ap = l2d[4+2*k +: 2]; end
            else if (l2d[1:0] == 2) begin k = m[11:10]; p = {l2d[31:12], m[11:0]}; ap = l2d[4+2*k +: 2]; end
            else begin p = {l2d[31:10], m[9:0]}; ap = l2d[5:4]; end
        end
        case (ap)
            0: okp = !wr && ((cfg_pmode == 2'b01 && !u) || cfg_pmode == 2'b10);
            1: okp = !u;
            2: okp = !(u && wr);
            default: okp = 1'b1;
        endcase
        if (dv == 3 || okp) return {1'b0, 8'h00, p};
        return {1'b1, d, (l1d[1:0] == 2) ? 4'd13 : 4'd15, 32'h0};
    endfunction

    task automatic xlat(input string req, input logic [31:0] v, input logic [1:0] a, input logic u);
        logic [40:0] e;
        logic [31:0] mm;
        bit waited = 0, got = 0;
        e  = model(v, a, u);
        mm = (v < 32'h0200_0000) ? v + cfg_pid : v;
        nreads = 0;
        @(negedge clk); start = 1'b1; va = v; acc = a; user = u;
        @(negedge clk); start = 1'b0;
        for (int n = 0; n < 40 && !got; n++) begin
            rd_ready = 1'b0;
            if (done) begin
                got = 1;
                if (e[40]) check({req, " fault/fstat"}, {fault, fstat}, {1'b1, e[39:32]});
                else       check({req, " pa"}, {fault, pa}, {1'b0, e[31:0]});
            end else if (rd_valid) begin
                if (waited) begin
                    waited = 0;
                    if (nreads == 0) begin
                        check("R3 l1 addr", rd_addr, {cfg_base[31:14], mm[31:20], 2'b00});
                        rd_data = l1d;
                    end else begin
                        check("R6 l2 addr", rd_addr, {l1d[31:10], mm[19:12], 2'b00});
                        rd_data = l2d;
                    end
                    rd_ready = 1'b1;
                    nreads++;
                end else waited = 1;
            end
            if (!got) @(negedge clk);
        end
        if (!got) check({req, " done timeout"}, 0, 1);
        @(negedge clk);
        check("R12 done single", done, 0);
    endtask

    initial begin
        #4_000_000;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R12 reset done", {done, rd_valid, fault}, 0);

        // R1 R2 remap and bypass
        cfg_en = 0; cfg_pid = 32'h0100_0000;
        l1d = 0; l2d = 0;
        xlat("R1 low", 32'h0000_1234, 0, 0);
        check("R2 no reads", nreads, 0);
        xlat("R1 edge below", 32'h01FF_FFFF, 1, 1);
        xlat("R1 at limit", 32'h0200_0000, 2, 0);
        xlat("R2 high", 32'hCAFE_0123, 1, 0);

        cfg_en = 1;
        // R3 invalid l1
        l1d = 32'h1234_5160; cfg_dacr = 32'hFFFF_FFFF;
        xlat("R3 type0", 32'h8765_4321, 0, 0);

        // R5 R9 R10 R13 section permission sweep, domain 6 client
        cfg_dacr = 32'h0000_1000;
        for (int ap = 0; ap < 4; ap++)
            for (int pm = 0; pm < 4; pm++)
                for (int u = 0; u < 2; u++)
                    for (int a = 0; a < 3; a++) begin
                        cfg_pmode = pm[1:0];
                        l1d = 32'hABC0_00C2 | (ap << 10);
                        xlat("R5 R9 R10 R13 section", 32'h3217_6543 + a * 32'h100_0000, a[1:0], u[0]);
                    end

        // R4 domain override; R1 with translation on
        cfg_pmode = 2'b00;
        for (int dv = 0; dv < 4; dv++)
            for (int t = 1; t < 4; t++) begin
                cfg_dacr = dv << 18;
                l1d = 32'h5550_0000 | 32'h120 | t;
                l2d = 32'h7777_7002;
                xlat("R4 R11 domain", 32'h0012_3456, 1, 1);
            end

        // R6 R7 R8 second level sweep
        cfg_dacr = 32'h4000_0000; cfg_pid = 32'h0040_0000;
        for (int t1 = 1; t1 < 4; t1 += 2)
            for (int t2 = 0; t2 < 4; t2++)
                for (int r = 0; r < 4; r++)
                    for (int k = 0; k < 4; k++)
                        for (int w = 0; w < 2; w++) begin
                            logic [7:0] aps;
                            for (int j = 0; j < 4; j++) aps[2*j +: 2] = 2'((j + r) % 4);
                            l1d = 32'h0BAD_C000 | 32'h1E0 | t1;
                            l2d = 32'h9876_5000 | (aps << 4) | t2;
                            xlat("R6 R7 R8 page", 32'h4135_0000 | (k << 14) | (k << 10) | 32'h3A5,
                                 w[1:0], 1'b1);
                        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule